// File: doc/BRIEF.md
# Synthesizer Divider Update Controller

This block is the digital control layer that sits between a register-write port and the divider inputs of a fractional-N synthesizer. Software writes the integer and fractional divider values, an alternate divider pair, a phase step and a seed through a plain address/data/strobe port. The block then presents the active divider pair, a phase offset and a one-cycle seed-load pulse to the modulator.

A 3-bit mode field decides how divider writes are buffered and what a trigger does. The trigger can be a plain frequency update, a level-held switch between two frequencies, or a phase step up or down. A trigger comes from an external pin, from a software bit in the control register, or from a fractional write in the frequency-hopping modes. The external pin first passes through a two-flop synchronizer.

Register map (3-bit address): 0 control, 1 primary integer, 2 primary fractional, 3 seed, 4 phase step, 5 alternate integer, 6 alternate fractional. Control bits: [2:0] mode, [3] external-pin enable, [4] autoseed, [5] software trigger, [6] phase direction (1 = decrement). Integer registers take the low INT_W data bits.

Top module: `synth_div_ctrl`

## Requirements
- R1: After reset, every output is zero and no seed-load pulse is present. The mode is 0.
- R2: In modes 0 and 2 with the pin enable set, integer and fractional writes leave the outputs unchanged. A trigger rising edge copies both held values to the outputs, visible one cycle after the edge is seen.
- R3: The pin has no effect while its enable bit is clear. With the bit set, a pin rise changes the outputs after the third rising clock edge that samples it high.
- R4: In modes 0 and 2 with the pin enable clear, an integer write alone changes nothing. A fractional write makes the held integer and the new fraction active together, from the clock edge that takes the write.
- R5: Only a 0-to-1 change of the software trigger bit is a trigger. Rewriting it as 1 while it is already 1 does nothing.
- R6: In mode 1 an integer write appears on the integer output after the edge that takes it, and the fractional output reads 0.
- R7: In mode 3, while the trigger level is high the outputs show the alternate pair. While it is low they show the primary pair as last written.
- R8: In mode 4 each trigger adds the step to the phase offset, or subtracts it when the direction bit is 1. The result wraps modulo 2^FRAC_W.
- R9: With autoseed set, a trigger or a committing fractional write gives a one-cycle seed-load pulse in the cycle the new divider pair becomes active. No pulse occurs with autoseed clear. The seed output shows the seed register.
- R10: Writes to registers the mode does not use are accepted but change no output. In modes 5 to 7 triggers change neither the dividers nor the phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | FRAC_W | Write data |
| trig_pin | input | 1 | Asynchronous external trigger |
| div_int | output | INT_W | Active integer divider |
| div_frac | output | FRAC_W | Active fractional divider |
| phase_ofs | output | FRAC_W | Phase offset |
| seed_val | output | FRAC_W | Seed value for the modulator |
| seed_load | output | 1 | One-cycle seed-load strobe |

## Verification
The hardest case to reach is the gap between a pin trigger and its effect. The pin must be qualified by the enable, carried through the synchronizer, and edge-detected before the commit. The bench raises the pin once with the enable clear and once with it set, and checks the output on the sample points after the second and third clock edges. For phase wrap, a decrement from zero is set up through a series of software triggers in a fixed vector table.

// File: rtl/synth_div_ctrl.sv
module synth_div_ctrl #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [FRAC_W-1:0] wr_data,
  input  logic              trig_pin,
  output logic [INT_W-1:0]  div_int,
  output logic [FRAC_W-1:0] div_frac,
  output logic [FRAC_W-1:0] phase_ofs,
  output logic [FRAC_W-1:0] seed_val,
  output logic              seed_load
);

  localparam logic [2:0] A_CTRL = 3'd0, A_INT = 3'd1, A_FRAC = 3'd2, A_SEED = 3'd3,
                         A_STEP = 3'd4, A_AINT = 3'd5, A_AFRAC = 3'd6;
  localparam logic [2:0] M_FRAC = 3'd0, M_INT = 3'd1, M_EXACT = 3'd2, M_FM = 3'd3, M_PM = 3'd4;

  logic [2:0]        mode_q;
  logic              ext_en_q, autoseed_q, sw_trig_q, pm_dec_q;
  logic [INT_W-1:0]  sh_int, alt_int, act_int;
  logic [FRAC_W-1:0] sh_frac, alt_frac, act_frac, step_q, seed_q, phase_q;
  logic              sync1, sync2, src_q, seed_load_q;

  wire wr_ctl  = wr_en && wr_addr == A_CTRL;
  wire wr_int  = wr_en && wr_addr == A_INT;
  wire wr_frac = wr_en && wr_addr == A_FRAC;

  wire hop_mode    = mode_q == M_FRAC || mode_q == M_EXACT;
  wire trig_src    = (ext_en_q & sync2) | sw_trig_q;
  wire edge_evt    = trig_src & ~src_q;
  wire trig_evt    = edge_evt & (hop_mode || mode_q == M_FM || mode_q == M_PM);
  wire frac_commit = wr_frac & hop_mode & ~ext_en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= M_FRAC; ext_en_q <= 1'b0; autoseed_q <= 1'b0;
      sw_trig_q <= 1'b0; pm_dec_q <= 1'b0;
      sh_int <= '0; sh_frac <= '0; alt_int <= '0; alt_frac <= '0;
      step_q <= '0; seed_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          mode_q     <= wr_data[2:0];
          ext_en_q   <= wr_data[3];
          autoseed_q <= wr_data[4];
          sw_trig_q  <= wr_data[5];
          pm_dec_q   <= wr_data[6];
        end
        A_INT:   sh_int   <= wr_data[INT_W-1:0];
        A_FRAC:  sh_frac  <= wr_data;
        A_SEED:  seed_q   <= wr_data;
        A_STEP:  step_q   <= wr_data;
        A_AINT:  alt_int  <= wr_data[INT_W-1:0];
        A_AFRAC: alt_frac <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= 1'b0; sync2 <= 1'b0; src_q <= 1'b0;
    end else begin
      sync1 <= trig_pin; sync2 <= sync1; src_q <= trig_src;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_int <= '0; act_frac <= '0;
    end else if (mode_q == M_INT && wr_int) begin
      act_int <= wr_data[INT_W-1:0];
    end else if (frac_commit) begin
      act_int <= sh_int; act_frac <= wr_data;
    end else if (hop_mode && trig_evt) begin
      act_int <= sh_int; act_frac <= sh_frac;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        phase_q <= '0;
    else if (mode_q == M_PM && trig_evt) phase_q <= pm_dec_q ? phase_q - step_q : phase_q + step_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) seed_load_q <= 1'b0;
    else        seed_load_q <= autoseed_q & (trig_evt | frac_commit);
  end

  assign div_int   = mode_q == M_FM ? (trig_src ? alt_int : sh_int) : act_int;
  assign div_frac  = mode_q == M_INT ? '0 :
                     mode_q == M_FM  ? (trig_src ? alt_frac : sh_frac) : act_frac;
  assign phase_ofs = phase_q;
  assign seed_val  = seed_q;
  assign seed_load = seed_load_q;

  AST_HOLD_UNTIL_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    (hop_mode && ext_en_q && !trig_evt) |=> ($stable(act_int) && $stable(act_frac))); // R2
  AST_INT_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_INT && wr_int) |=> div_int == $past(wr_data[INT_W-1:0])); // R6
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode_q == M_PM && trig_evt) |=> $stable(phase_q)); // R8
  AST_PHASE_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_PM && trig_evt && !pm_dec_q) |=> (phase_q - $past(phase_q)) == $past(step_q)); // R8
  AST_SEED_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |-> $past(autoseed_q)); // R9
  AST_RAMP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q >= 3'd5) |=> ($stable(act_frac) && $stable(phase_q))); // R10

endmodule

// File: tb/sim_synth_div_ctrl.sv
module sim_synth_div_ctrl;
  localparam int INT_W = 16, FRAC_W = 24;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, trig_pin = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [FRAC_W-1:0] wr_data = '0;
  logic [INT_W-1:0] div_int;
  logic [FRAC_W-1:0] div_frac, phase_ofs, seed_val;
  logic seed_load;
  int checks = 0, failures = 0, cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  synth_div_ctrl #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .trig_pin(trig_pin), .div_int(div_int), .div_frac(div_frac), .phase_ofs(phase_ofs),
    .seed_val(seed_val), .seed_load(seed_load));

  // row: req[95:92] addr[91:88] data[87:64] int[63:48] frac[47:24] phase[23:0]
  localparam logic [95:0] VEC [16] = '{
    {4'd4,  4'd1, 24'h000010, 16'h0000, 24'h000000, 24'h000000},  // R4 int held
    {4'd4,  4'd2, 24'h123456, 16'h0010, 24'h123456, 24'h000000},  // R4 frac commits pair
    {4'd10, 4'd5, 24'h000022, 16'h0010, 24'h123456, 24'h000000},  // R10 alt unused
    {4'd6,  4'd0, 24'h000001, 16'h0010, 24'h000000, 24'h000000},  // R6 integer mode
    {4'd6,  4'd1, 24'h000033, 16'h0033, 24'h000000, 24'h000000},  // R6 immediate
    {4'd10, 4'd4, 24'h000005, 16'h0033, 24'h000000, 24'h000000},  // R10 step unused
    {4'd2,  4'd0, 24'h00000A, 16'h0033, 24'h123456, 24'h000000},  // R2 mode 2, pin enable
    {4'd2,  4'd1, 24'h000044, 16'h0033, 24'h123456, 24'h000000},  // R2 int held
    {4'd2,  4'd2, 24'h0ABCDE, 16'h0033, 24'h123456, 24'h000000},  // R2 frac held
    {4'd2,  4'd0, 24'h00002A, 16'h0044, 24'h0ABCDE, 24'h000000},  // R2 sw trigger
    {4'd5,  4'd0, 24'h00000A, 16'h0044, 24'h0ABCDE, 24'h000000},  // R5 clear bit
    {4'd8,  4'd0, 24'h000024, 16'h0044, 24'h0ABCDE, 24'h000005},  // R8 step up
    {4'd8,  4'd0, 24'h000004, 16'h0044, 24'h0ABCDE, 24'h000005},  // R8
    {4'd8,  4'd0, 24'h000064, 16'h0044, 24'h0ABCDE, 24'h000000},  // R8 step down
    {4'd8,  4'd0, 24'h000044, 16'h0044, 24'h0ABCDE, 24'h000000},  // R8
    {4'd8,  4'd0, 24'h000064, 16'h0044, 24'h0ABCDE, 24'hFFFFFB}   // R8 wrap below zero
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [FRAC_W-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(3);
    chk("R1 int", 32'(div_int), 0);
    chk("R1 frac", 32'(div_frac), 0);
    chk("R1 phase", 32'(phase_ofs), 0);
    chk("R1 seed", 32'(seed_load), 0);
    rst_n = 1'b1;
    idle(1);

    for (int i = 0; i < 16; i++) begin
      wr(VEC[i][90:88], VEC[i][87:64]);
      @(posedge clk); @(negedge clk);
      chk($sformatf("R%0d row%0d int", VEC[i][95:92], i), 32'(div_int), 32'(VEC[i][63:48]));
      chk($sformatf("R%0d row%0d frac", VEC[i][95:92], i), 32'(div_frac), 32'(VEC[i][47:24]));
      chk($sformatf("R%0d row%0d phase", VEC[i][95:92], i), 32'(phase_ofs), 32'(VEC[i][23:0]));
    end

    // R5: rewrite of a held software trigger bit
    wr(3'd0, 24'h64); idle(2);
    chk("R5 no retrigger", 32'(phase_ofs), 32'hFFFFFB);

    // R3: pin ignored without enable, then synchronized rise with enable
    wr(3'd0, 24'h04);
    trig_pin = 1'b1; idle(4);
    chk("R3 pin ignored", 32'(phase_ofs), 32'hFFFFFB);
    trig_pin = 1'b0; idle(3);
    wr(3'd0, 24'h0C);
    trig_pin = 1'b1;
    idle(2);
    chk("R3 two edges", 32'(phase_ofs), 32'hFFFFFB);
    idle(1);
    chk("R3 third edge", 32'(phase_ofs), 32'h000000);
    trig_pin = 1'b0; idle(3);

    // R2/R3: divider commit by pin in mode 0
    wr(3'd0, 24'h08);
    wr(3'd1, 24'h55);
    wr(3'd2, 24'h0F0F0F);
    chk("R2 held int", 32'(div_int), 32'h44);
    trig_pin = 1'b1; idle(3);
    chk("R3 pin int", 32'(div_int), 32'h55);
    chk("R3 pin frac", 32'(div_frac), 32'h0F0F0F);
    trig_pin = 1'b0; idle(3);

    // R4: paired commit without pin enable
    wr(3'd0, 24'h00);
    wr(3'd1, 24'h66); idle(2);
    chk("R4 int alone", 32'(div_int), 32'h55);
    wr(3'd2, 24'h111111);
    chk("R4 pair int", 32'(div_int), 32'h66);
    chk("R4 pair frac", 32'(div_frac), 32'h111111);

    // R7: level-held frequency switch
    wr(3'd6, 24'h222222);
    wr(3'd0, 24'h03);
    chk("R7 low int", 32'(div_int), 32'h66);
    wr(3'd0, 24'h23);
    chk("R7 high int", 32'(div_int), 32'h22);
    chk("R7 high frac", 32'(div_frac), 32'h222222);
    wr(3'd0, 24'h03);
    chk("R7 back frac", 32'(div_frac), 32'h111111);

    // R9: seed-load strobe
    wr(3'd3, 24'hABCDEF);
    chk("R9 seed value", 32'(seed_val), 32'hABCDEF);
    wr(3'd0, 24'h10);
    wr(3'd2, 24'h000777);
    chk("R9 frac pulse", 32'(seed_load), 1);
    idle(1);
    chk("R9 frac pulse end", 32'(seed_load), 0);
    wr(3'd0, 24'h30);
    chk("R9 trig before", 32'(seed_load), 0);
    idle(1);
    chk("R9 trig pulse", 32'(seed_load), 1);
    idle(1);
    chk("R9 trig end", 32'(seed_load), 0);
    wr(3'd0, 24'h10);
    wr(3'd0, 24'h20);
    for (int i = 0; i < 3; i++) begin
      chk("R9 no autoseed", 32'(seed_load), 0);
      idle(1);
    end

    // R10: ramp modes ignore triggers
    wr(3'd0, 24'h05);
    wr(3'd1, 24'h99);
    wr(3'd0, 24'h25); idle(2);
    chk("R10 ramp int", 32'(div_int), 32'h66);
    chk("R10 ramp frac", 32'(div_frac), 32'h000777);
    chk("R10 ramp phase", 32'(phase_ofs), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule